// File: doc/BRIEF.md
# Streaming Full-Duplex SPI Master

This block is a serial peripheral bus master that moves bytes between two internal FIFOs and the wire. The host pushes bytes into a transmit FIFO. The engine takes each byte out, clocks it onto MOSI most-significant bit first, and at the same time gathers eight MISO bits. Each gathered byte goes into a receive FIFO for the host to pop. Because the bus is full duplex, every byte sent yields exactly one byte received. A read-only transfer is therefore done by sending filler bytes.

Clock phase and clock polarity are fixed when the block is built. Polarity changes only the output inversion of SCK, so the internal sequence is the same for both settings. A fractional divider with eight fraction bits produces a tick enable. Each bit takes exactly four ticks, so the divider ratio is the system clock divided by four times the wanted SCK rate. The default ratio gives 1 MHz from a 250 MHz clock.

If the transmit FIFO is empty at a byte boundary, the engine parks with SCK at its idle level. It also parks if the receive FIFO has no room. In both cases it raises a sticky stall flag. The host treats "transmit FIFO empty and flag set" as the sign that the last bit has left the wire.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, SCK rests at its idle level, MOSI is 0, both FIFOs report empty and `stalled` is 1.
- R2: One tick fires for every DIV/256 clocks on average. Each bit lasts exactly 4 ticks, so with bytes back to back, the leading edges of bit 0 of two consecutive bytes are 32·DIV/256 clocks apart. With DIV = 0x180, consecutive leading edges are 6 clocks apart.
- R3: A DIV below 0x100 acts as 0x100: one tick per clock, a leading edge every 4 clocks and an active SCK half of 2 clocks.
- R4: With CPHA = 0, MOSI changes while SCK is idle, two ticks before the leading edge, and MISO is sampled on the leading edge. With CPHA = 1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: When the transmit FIFO is empty at a byte boundary, no further SCK edges occur and SCK stays idle. Shifting resumes by itself once a byte is pushed.
- R6: Both directions shift bit 7 first. The k-th pushed byte is the k-th byte on MOSI, and the k-th byte on MISO is the k-th byte popped from the receive FIFO.
- R7: The idle level of the SCK pin equals CPOL. The leading edge is rising for CPOL = 0 and falling for CPOL = 1.
- R8: `stalled` is set in the cycle the engine enters a stall. It is cleared by a `stall_clr` pulse and by the start of a byte. If a set and a `stall_clr` fall in the same cycle, the set wins.
- R9: If the receive FIFO is full at a byte boundary, the engine stalls with SCK idle and keeps the untaken transmit bytes. No received byte is lost, and shifting resumes after a pop frees space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_wdata | input | 8 | Byte to queue for sending |
| tx_push | input | 1 | Write strobe for the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO has no free entry |
| tx_empty | output | 1 | Transmit FIFO holds no byte |
| rx_rdata | output | 8 | Oldest received byte (show-ahead) |
| rx_pop | input | 1 | Removes the oldest received byte |
| rx_empty | output | 1 | Receive FIFO holds no byte |
| rx_full | output | 1 | Receive FIFO has no free entry |
| stall_clr | input | 1 | Clear-on-read strobe for the stall flag |
| stalled | output | 1 | Sticky stall flag |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two pairs of events can fall in the same clock cycle.

The first pair is a host push and the engine's own pop of the transmit FIFO. The bench provokes it with random gaps between pushes, so some bytes arrive exactly in the tick where the engine decides between starting a byte and stalling. It judges the outcome by comparing every byte seen on MOSI and every byte popped from the receive FIFO against the expected order.

The second pair is a `stall_clr` pulse and a stall entry. The bench holds `stall_clr` high across a whole transfer and expects `stalled` to read 1 for exactly one cycle, the cycle in which the set overrode the clear.

// File: rtl/spi_fifo_master.sv
`timescale 1ns/1ps
module spi_fifo_master #(
  parameter int unsigned CPHA     = 0,
  parameter int unsigned CPOL     = 0,
  parameter logic [23:0] DIV      = 24'h003E80,
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_wdata,
  input  logic       tx_push,
  output logic       tx_full,
  output logic       tx_empty,
  output logic [7:0] rx_rdata,
  input  logic       rx_pop,
  output logic       rx_empty,
  output logic       rx_full,
  input  logic       stall_clr,
  output logic       stalled,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int unsigned TAW = (TX_DEPTH > 1) ? $clog2(TX_DEPTH) : 1;
  localparam int unsigned RAW = (RX_DEPTH > 1) ? $clog2(RX_DEPTH) : 1;
  localparam logic [TAW-1:0] TX_LAST = TAW'(TX_DEPTH - 1);
  localparam logic [RAW-1:0] RX_LAST = RAW'(RX_DEPTH - 1);
  localparam logic [TAW:0]   TX_N    = (TAW+1)'(TX_DEPTH);
  localparam logic [RAW:0]   RX_N    = (RAW+1)'(RX_DEPTH);
  localparam logic [24:0]    ONE     = 25'h000100;
  localparam logic [24:0]    DIVC    = ({1'b0, DIV} < ONE) ? ONE : {1'b0, DIV};

  logic [24:0] acc, acc_sum;
  logic        tick;

  assign acc_sum = acc + ONE;
  assign tick    = acc_sum >= DIVC;

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= tick ? acc_sum - DIVC : acc_sum;
  end

  logic [7:0]     tx_mem [TX_DEPTH];
  logic [TAW-1:0] tx_rp, tx_wp;
  logic [TAW:0]   tx_cnt;
  logic           tx_wr, tx_rd;

  logic [7:0]     rx_mem [RX_DEPTH];
  logic [RAW-1:0] rx_rp, rx_wp;
  logic [RAW:0]   rx_cnt;
  logic           rx_wr, rx_rd;
  logic [7:0]     rx_in;

  assign tx_full  = tx_cnt == TX_N;
  assign tx_empty = tx_cnt == '0;
  assign rx_full  = rx_cnt == RX_N;
  assign rx_empty = rx_cnt == '0;
  assign rx_rdata = rx_mem[rx_rp];
  assign tx_wr    = tx_push && !tx_full;
  assign rx_rd    = rx_pop && !rx_empty;

  always_ff @(posedge clk) begin
    if (tx_wr) tx_mem[tx_wp] <= tx_wdata;
    if (rx_wr) rx_mem[rx_wp] <= rx_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_wr) tx_wp <= (tx_wp == TX_LAST) ? '0 : tx_wp + 1'b1;
      if (tx_rd) tx_rp <= (tx_rp == TX_LAST) ? '0 : tx_rp + 1'b1;
      if (rx_wr) rx_wp <= (rx_wp == RX_LAST) ? '0 : rx_wp + 1'b1;
      if (rx_rd) rx_rp <= (rx_rp == RX_LAST) ? '0 : rx_rp + 1'b1;
      tx_cnt <= tx_cnt + (TAW+1)'(tx_wr) - (TAW+1)'(tx_rd);
      rx_cnt <= rx_cnt + (RAW+1)'(rx_wr) - (RAW+1)'(rx_rd);
    end
  end

  logic [1:0] ph;
  logic [2:0] bc;
  logic [7:0] txsh, rxsh;
  logic       stall_q, flag, sck_i, mosi_q;
  logic       at_start, go;

  assign at_start = (ph == 2'd0) && (bc == 3'd0);
  assign go       = !tx_empty && !rx_full;
  assign tx_rd    = tick && at_start && go;
  assign rx_wr    = tick && (ph == 2'd3) && (bc == 3'd7);
  assign rx_in    = (CPHA != 0) ? {rxsh[6:0], miso} : rxsh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0; bc <= '0; txsh <= '0; rxsh <= '0;
      stall_q <= 1'b1; flag <= 1'b1; sck_i <= 1'b0; mosi_q <= 1'b0;
    end else begin
      if (stall_clr) flag <= 1'b0;
      if (tick) begin
        case (ph)
          2'd0: begin
            sck_i <= 1'b0;
            if (bc == 3'd0 && !go) begin
              if (!stall_q) begin
                stall_q <= 1'b1;
                flag    <= 1'b1;
              end
            end else begin
              ph <= 2'd1;
              if (bc == 3'd0) begin
                txsh    <= tx_mem[tx_rp];
                stall_q <= 1'b0;
                flag    <= 1'b0;
              end
              if (CPHA == 0) mosi_q <= (bc == 3'd0) ? tx_mem[tx_rp][7] : txsh[7];
            end
          end
          2'd1: begin
            ph <= 2'd2;
            if (CPHA != 0) begin
              sck_i  <= 1'b1;
              mosi_q <= txsh[7];
            end
          end
          2'd2: begin
            ph <= 2'd3;
            if (CPHA == 0) begin
              sck_i <= 1'b1;
              rxsh  <= {rxsh[6:0], miso};
            end
          end
          2'd3: begin
            ph   <= 2'd0;
            bc   <= bc + 3'd1;
            txsh <= {txsh[6:0], 1'b0};
            if (CPHA != 0) begin
              sck_i <= 1'b0;
              rxsh  <= {rxsh[6:0], miso};
            end
          end
        endcase
      end
    end
  end

  assign sck     = sck_i ^ (CPOL != 0);
  assign mosi    = mosi_q;
  assign stalled = flag;
endmodule

module spi_fifo_master_chk #(
  parameter int unsigned CPOL     = 0,
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8,
  parameter int unsigned TAW      = 3,
  parameter int unsigned RAW      = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sck,
  input logic         stalled,
  input logic         stall_q,
  input logic         tick,
  input logic [1:0]   ph,
  input logic [2:0]   bc,
  input logic [TAW:0] tx_cnt,
  input logic [RAW:0] rx_cnt,
  input logic         rx_wr,
  input logic         rx_full
);
  assert_idle_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q |-> (sck == (CPOL != 0)));

  assert_paced_by_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(ph) && $stable(bc)));

  assert_flag_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stalled) |-> stall_q);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr |-> !rx_full);

  assert_rx_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_cnt) <= RX_DEPTH);

  assert_tx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tx_cnt) <= TX_DEPTH);
endmodule

bind spi_fifo_master spi_fifo_master_chk #(
  .CPOL(CPOL), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .TAW(TAW), .RAW(RAW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .stalled(stalled), .stall_q(stall_q),
  .tick(tick), .ph(ph), .bc(bc), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .rx_wr(rx_wr), .rx_full(rx_full)
);

// File: tb/test_spi_fifo_master.sv
`timescale 1ns/1ps
module spi_slave_model #(
  parameter int unsigned CPHA = 0,
  parameter int unsigned CPOL = 0
) (
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  logic [7:0] sin;
  logic [7:0] got [0:127];
  time        lead_t  [0:1023];
  time        trail_t [0:1023];
  int         bits, nrx, nlead, ntrail;
  logic       last;

  function automatic logic [7:0] answer(input int k);
    return 8'((k * 73) ^ 8'h5A);
  endfunction

  task automatic take();
    sin = {sin[6:0], mosi};
    bits++;
    if (bits == 8) begin
      if (nrx < 128) got[nrx] = sin;
      nrx++;
      bits = 0;
    end
  endtask

  task automatic put();
    logic [7:0] r;
    r = answer(nrx);
    miso = r[3'(7 - bits)];
  endtask

  initial begin
    last = (CPOL != 0);
    sin = '0; bits = 0; nrx = 0; nlead = 0; ntrail = 0;
    put();
  end

  always @(sck) begin
    if (!$isunknown(sck) && sck !== last) begin
      last = sck;
      if (sck != (CPOL != 0)) begin
        if (nlead < 1024) lead_t[nlead] = $time;
        nlead++;
        if (CPHA == 0) begin take(); put(); end
        else put();
      end else begin
        if (ntrail < 1024) trail_t[ntrail] = $time;
        ntrail++;
        if (CPHA != 0) take();
      end
    end
  end
endmodule

module test_spi_fifo_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] tx_wdata = '0;
  logic       tx_push = 1'b0, stall_clr = 1'b0;
  logic       rx_pop_a = 1'b0, rx_pop_b = 1'b0;
  logic       tx_full_a, tx_empty_a, rx_empty_a, rx_full_a, stalled_a, sck_a, mosi_a, miso_a;
  logic       tx_full_b, tx_empty_b, rx_empty_b, rx_full_b, stalled_b, sck_b, mosi_b, miso_b;
  logic [7:0] rx_rdata_a, rx_rdata_b;

  spi_fifo_master #(.CPHA(0), .CPOL(0), .DIV(24'h000180), .TX_DEPTH(8), .RX_DEPTH(8)) i_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .tx_wdata(tx_wdata), .tx_push(tx_push), .tx_full(tx_full_a),
    .tx_empty(tx_empty_a), .rx_rdata(rx_rdata_a), .rx_pop(rx_pop_a), .rx_empty(rx_empty_a),
    .rx_full(rx_full_a), .stall_clr(stall_clr), .stalled(stalled_a), .sck(sck_a),
    .mosi(mosi_a), .miso(miso_a));

  spi_fifo_master #(.CPHA(1), .CPOL(1), .DIV(24'h000080), .TX_DEPTH(8), .RX_DEPTH(8)) i_spi_fifo_master_b (
    .clk(clk), .rst_n(rst_n), .tx_wdata(tx_wdata), .tx_push(tx_push), .tx_full(tx_full_b),
    .tx_empty(tx_empty_b), .rx_rdata(rx_rdata_b), .rx_pop(rx_pop_b), .rx_empty(rx_empty_b),
    .rx_full(rx_full_b), .stall_clr(stall_clr), .stalled(stalled_b), .sck(sck_b),
    .mosi(mosi_b), .miso(miso_b));

  spi_slave_model #(.CPHA(0), .CPOL(0)) i_slave_a (.sck(sck_a), .mosi(mosi_a), .miso(miso_a));
  spi_slave_model #(.CPHA(1), .CPOL(1)) i_slave_b (.sck(sck_b), .mosi(mosi_b), .miso(miso_b));

  int nchk = 0, nerr = 0, nsent = 0, rxk_a = 0, rxk_b = 0;
  logic [7:0] sent [0:127];
  bit finished = 0;

  function automatic logic [7:0] expect_miso(input int k);
    return 8'((k * 73) ^ 8'h5A);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    while (tx_full_a || tx_full_b) @(negedge clk);
    tx_wdata = b; tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
    sent[nsent] = b;
    nsent++;
  endtask

  task automatic wait_done();
    int n = 0;
    do begin @(negedge clk); n++; end
    while (!(tx_empty_a && stalled_a && tx_empty_b && stalled_b) && n < 5000);
  endtask

  task automatic drain(input bit sel, input int upto);
    int guard = 0;
    while ((sel ? rxk_b : rxk_a) < upto && guard < 20000) begin
      guard++;
      if (!(sel ? rx_empty_b : rx_empty_a)) begin
        if (sel) begin
          chk("R6 R4 rx byte (B)", rx_rdata_b, expect_miso(rxk_b));
          chk("R6 R4 mosi byte (B)", i_slave_b.got[rxk_b], sent[rxk_b]);
          rxk_b++; rx_pop_b = 1'b1;
        end else begin
          chk("R6 R4 rx byte (A)", rx_rdata_a, expect_miso(rxk_a));
          chk("R6 R4 mosi byte (A)", i_slave_a.got[rxk_a], sent[rxk_a]);
          rxk_a++; rx_pop_a = 1'b1;
        end
        @(negedge clk);
        rx_pop_a = 1'b0; rx_pop_b = 1'b0;
      end else @(negedge clk);
    end
    chk("R6 drain count", sel ? rxk_b : rxk_a, upto);
  endtask

  initial begin
    int seed, ones_a, ones_b, la, lb;
    seed = 1234;
    void'($urandom(seed));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 stalled A", stalled_a, 1);
    chk("R1 stalled B", stalled_b, 1);
    chk("R1 R7 sck idle A", sck_a, 0);
    chk("R1 R7 sck idle B", sck_b, 1);
    chk("R1 mosi A", mosi_a, 0);
    chk("R1 mosi B", mosi_b, 0);
    chk("R1 fifos empty A", {tx_empty_a, rx_empty_a}, 3);
    chk("R1 fifos empty B", {tx_empty_b, rx_empty_b}, 3);

    for (int i = 0; i < 4; i++) push_byte(8'($urandom));
    wait_done();
    chk("R2 bit period A", i_slave_a.lead_t[1] - i_slave_a.lead_t[0], 24);
    chk("R2 byte period A", i_slave_a.lead_t[8] - i_slave_a.lead_t[0], 192);
    chk("R3 bit period B", i_slave_b.lead_t[1] - i_slave_b.lead_t[0], 16);
    chk("R3 byte period B", i_slave_b.lead_t[8] - i_slave_b.lead_t[0], 128);
    chk("R3 active half B", i_slave_b.trail_t[0] - i_slave_b.lead_t[0], 8);
    chk("R8 completion A", {tx_empty_a, stalled_a}, 3);
    la = i_slave_a.nlead; lb = i_slave_b.nlead;
    repeat (60) @(negedge clk);
    chk("R5 no edges while stalled A", i_slave_a.nlead, la);
    chk("R5 no edges while stalled B", i_slave_b.nlead, lb);
    chk("R5 R7 sck idle A", sck_a, 0);
    chk("R5 R7 sck idle B", sck_b, 1);
    drain(0, nsent);
    drain(1, nsent);

    stall_clr = 1'b1;
    @(negedge clk);
    stall_clr = 1'b0;
    chk("R8 clear on read A", stalled_a, 0);
    chk("R8 clear on read B", stalled_b, 0);
    repeat (20) @(negedge clk);
    chk("R8 stays clear A", stalled_a, 0);
    chk("R8 stays clear B", stalled_b, 0);

    stall_clr = 1'b1;
    @(negedge clk);
    push_byte(8'($urandom));
    push_byte(8'($urandom));
    ones_a = 0; ones_b = 0;
    repeat (220) begin
      @(negedge clk);
      if (stalled_a) ones_a++;
      if (stalled_b) ones_b++;
    end
    stall_clr = 1'b0;
    chk("R8 set wins over clear A", ones_a, 1);
    chk("R8 set wins over clear B", ones_b, 1);
    drain(0, nsent);
    drain(1, nsent);

    for (int r = 0; r < 6; r++) begin
      int n;
      n = 1 + int'($urandom % 8);
      for (int i = 0; i < n; i++) begin
        push_byte(8'($urandom));
        repeat (int'($urandom % 60)) @(negedge clk);
      end
      wait_done();
      chk("R5 R6 frames on wire A", i_slave_a.nrx, nsent);
      chk("R5 R6 frames on wire B", i_slave_b.nrx, nsent);
      drain(0, nsent);
      drain(1, nsent);
    end

    for (int i = 0; i < 8; i++) push_byte(8'($urandom));
    wait_done();
    chk("R9 rx full A", rx_full_a, 1);
    chk("R9 rx full B", rx_full_b, 1);
    for (int i = 0; i < 3; i++) push_byte(8'($urandom));
    repeat (150) @(negedge clk);
    chk("R9 tx kept A", tx_empty_a, 0);
    chk("R9 tx kept B", tx_empty_b, 0);
    chk("R9 stalled A", stalled_a, 1);
    chk("R9 sck idle B", sck_b, 1);
    chk("R9 no extra frame A", i_slave_a.nrx, nsent - 3);
    chk("R9 no extra frame B", i_slave_b.nrx, nsent - 3);
    drain(0, nsent);
    drain(1, nsent);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule